// File: doc/BRIEF.md
# Opcode-Injection Bus Loader

This block lets an 8-bit processor with a 16-bit address space come up with no boot ROM. While the loader owns the bus, it never looks at the address lines. It counts processor bus cycles instead. On each read cycle it places the next byte of a scripted instruction stream on the data bus. On the few cycles where the script makes the processor touch real memory, it enables the chip select of the ROM or the RAM. In this way the processor runs short instruction snippets that the loader writes into the stream on the fly.

From these snippets the loader builds three things:

- **Reset handshake.** It holds the processor in reset, lets it start, and feeds the reset vector.
- **Memory primitives.** A store writes one byte to an address. A load reads one byte from a memory. Before each load it issues a jump to the vector, so the processor's program counter never wanders into the I/O window.
- **Two fixed programs.**
  - Copy mode moves a ROM image into RAM, one address at a time.
  - Program mode writes a RAM image into flash. Each byte write gets its unlock writes, and each sector gets an erase sequence.

Both programs skip the I/O window, set the ROM bank bit once they resume above it, and stop when the address counter wraps. The loader then raises `done` and releases the bus. There is no data stream interface at the edge. The processor paces every step through the `bus_cyc` strobe, and the loader cannot stall it, so there is no back-pressure.

Top module: `inj_loader`

## Requirements
- R1: While `rst_n` is low, the outputs are: `cpu_rst_n`=0, `bus_oe`=0, `rom_cs`=0, `ram_cs`=0, `done`=0, `hold_off`=1.
- R2: After reset, the first PRE_RST bus cycles keep `cpu_rst_n` low. The next POST_RST cycles release it and drive nothing. The next two cycles inject the low byte and then the high byte of VEC (default 0x8000). Once `cpu_rst_n` is high, it stays high.
- R3: A store injects 0xA9, data, 0x8D, address low, address high on five cycles. On the sixth cycle the loader leaves the bus undriven and asserts only the target memory's chip select. ROM and RAM selects are never both high.
- R4: A load injects 0x4C, VEC low, VEC high, 0xAD, address low, address high. On the seventh cycle the loader asserts the source memory's select and captures `bus_din` at the end of that cycle.
- R5: Copy mode (`prog_mode`=0 during the reset handshake) starts at address 0. For each address it loads from ROM, then stores the captured byte to RAM at the same address.
- R6: When the incremented address equals IO_LO, the address becomes IO_RESUME and `rom_bank` becomes 1. `rom_bank` is 0 before that point.
- R7: The store for the last address before the ADDR_W-bit counter wraps to 0 ends the run. After that, `done`=1, `hold_off`=0, and no select or bus drive is active. This holds until reset.
- R8: Program mode (`prog_mode`=1 during the reset handshake) writes each byte with four stores and one load, in this order:
  - ROM stores of 0xAA to UNLK_A, then 0x55 to UNLK_B, then 0xA0 to UNLK_A.
  - A load from RAM.
  - A ROM store of the captured byte.
- R9: In program mode, an address whose low SECTOR_W bits are zero is first preceded by six ROM stores, in this order: 0xAA→UNLK_A, 0x55→UNLK_B, 0x80→UNLK_A, 0xAA→UNLK_A, 0x55→UNLK_B, 0x30→address.
- R10: On injected cycles, `bus_oe` follows `cpu_rw` (1 = read). A cycle with `cpu_rw`=0 gets no drive but still consumes its scripted byte.
- R11: The script advances only at clock edges where `bus_cyc` is 1. Clocks with `bus_cyc` low change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset of the loader |
| bus_cyc | input | 1 | High for one clock at the end of each processor bus cycle |
| cpu_rw | input | 1 | Processor read (1) / write (0) indication |
| bus_din | input | 8 | Data bus as seen by the loader (memory read data) |
| prog_mode | input | 1 | 0 = copy ROM to RAM, 1 = program flash from RAM |
| cpu_rst_n | output | 1 | Processor reset, active low |
| bus_dout | output | 8 | Injected byte |
| bus_oe | output | 1 | Drive enable for `bus_dout` onto the data bus |
| rom_cs | output | 1 | ROM chip select for real memory cycles |
| ram_cs | output | 1 | RAM chip select for real memory cycles |
| rom_bank | output | 1 | ROM upper bank bit |
| hold_off | output | 1 | Holds other bus masters off while the loader is active |
| done | output | 1 | Run finished, bus released |

## Verification
The assertions assume that `bus_cyc` marks each processor bus cycle exactly once. They also assume that `prog_mode` is steady from reset until the vector has been fed. Neither assumption is checked. The bench plays a processor that follows the script. It pulses `bus_cyc` on every second clock, so each idle clock can show that outputs do not move. It returns memory data only on the cycles the script marks as real reads. The bench deliberately breaks the read indication on some injected cycles, which stays inside the rule that such a cycle still counts as one bus cycle.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  localparam int CPU_AW = 16;

  localparam logic [7:0] OPC_LDA_IMM = 8'hA9;
  localparam logic [7:0] OPC_STA_ABS = 8'h8D;
  localparam logic [7:0] OPC_JMP_ABS = 8'h4C;
  localparam logic [7:0] OPC_LDA_ABS = 8'hAD;

  localparam logic [7:0] FL_KEY1   = 8'hAA;
  localparam logic [7:0] FL_KEY2   = 8'h55;
  localparam logic [7:0] FL_ERASE  = 8'h80;
  localparam logic [7:0] FL_SECTOR = 8'h30;
  localparam logic [7:0] FL_WRITE  = 8'hA0;

  typedef enum logic [1:0] {OP_RESET, OP_STORE, OP_LOAD, OP_IDLE} op_kind_e;

  typedef struct packed {
    op_kind_e            kind;
    logic                to_rom;
    logic [CPU_AW-1:0]   addr;
    logic [7:0]          data;
  } op_t;
endpackage

// File: rtl/ldr_prim.sv
module ldr_prim
  import ldr_pkg::*;
#(
  parameter int PRE_RST  = 2,
  parameter int POST_RST = 5,
  parameter int VEC      = 'h8000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_cyc,
  input  op_t        op,
  input  logic [7:0] bus_din,
  output logic       inj,
  output logic [7:0] inj_byte,
  output logic       rom_cs,
  output logic       ram_cs,
  output logic       cpu_rst_n,
  output logic       op_last,
  output logic [7:0] cap_q
);
  localparam int LAST_RST = PRE_RST + POST_RST + 1;
  localparam int LAST_ST  = 5;
  localparam int LAST_LD  = 6;
  localparam int MAX_STEP = (LAST_RST > LAST_LD) ? LAST_RST : LAST_LD;
  localparam int STEP_W   = $clog2(MAX_STEP + 1);
  localparam logic [15:0] VEC_W = 16'(VEC);

  logic [STEP_W-1:0] step_q;
  int                step_i;

  assign step_i = int'(step_q);

  always_comb begin
    inj       = 1'b0;
    inj_byte  = '0;
    rom_cs    = 1'b0;
    ram_cs    = 1'b0;
    cpu_rst_n = 1'b1;
    op_last   = 1'b0;
    case (op.kind)
      OP_RESET: begin
        cpu_rst_n = (step_i >= PRE_RST);
        inj       = (step_i >= PRE_RST + POST_RST);
        inj_byte  = (step_i == LAST_RST) ? VEC_W[15:8] : VEC_W[7:0];
        op_last   = (step_i == LAST_RST);
      end
      OP_STORE: begin
        op_last = (step_i == LAST_ST);
        inj     = (step_i < LAST_ST);
        case (step_i)
          0:       inj_byte = OPC_LDA_IMM;
          1:       inj_byte = op.data;
          2:       inj_byte = OPC_STA_ABS;
          3:       inj_byte = op.addr[7:0];
          4:       inj_byte = op.addr[15:8];
          default: inj_byte = '0;
        endcase
        rom_cs = op_last && op.to_rom;
        ram_cs = op_last && !op.to_rom;
      end
      OP_LOAD: begin
        op_last = (step_i == LAST_LD);
        inj     = (step_i < LAST_LD);
        case (step_i)
          0:       inj_byte = OPC_JMP_ABS;
          1:       inj_byte = VEC_W[7:0];
          2:       inj_byte = VEC_W[15:8];
          3:       inj_byte = OPC_LDA_ABS;
          4:       inj_byte = op.addr[7:0];
          5:       inj_byte = op.addr[15:8];
          default: inj_byte = '0;
        endcase
        rom_cs = op_last && op.to_rom;
        ram_cs = op_last && !op.to_rom;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
      cap_q  <= '0;
    end else if (bus_cyc && op.kind != OP_IDLE) begin
      if (op_last) step_q <= '0;
      else         step_q <= step_q + 1'b1;
      if (op.kind == OP_LOAD && op_last) cap_q <= bus_din;
    end
  end
endmodule

// File: rtl/ldr_sched.sv
module ldr_sched
  import ldr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IO_LO     = 'h6000,
  parameter int IO_RESUME = 'h8000,
  parameter int SECTOR_W  = 12,
  parameter int UNLK_A    = 'h5555,
  parameter int UNLK_B    = 'h2AAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       prog_mode,
  input  logic [7:0] cap_q,
  output op_t        op,
  output logic       rom_bank,
  output logic       done
);
  localparam logic [ADDR_W-1:0] IO_LO_A  = ADDR_W'(IO_LO);
  localparam logic [ADDR_W-1:0] RESUME_A = ADDR_W'(IO_RESUME);
  localparam logic [15:0]       KA       = 16'(UNLK_A);
  localparam logic [15:0]       KB       = 16'(UNLK_B);
  localparam int                ERASE_N  = 6;
  localparam int                UNLK_N   = 3;

  typedef enum logic [2:0] {PH_RST, PH_ERASE, PH_UNLK, PH_LOAD, PH_STORE, PH_DONE} phase_e;

  phase_e            ph_q;
  logic [2:0]        idx_q;
  logic [ADDR_W-1:0] addr_q, inc_a, next_a;
  logic              mode_q, bank_q, wrap, skip, sec_start;
  logic [15:0]       addr16;

  assign addr16    = 16'(addr_q);
  assign inc_a     = addr_q + 1'b1;
  assign wrap      = (inc_a == '0);
  assign skip      = (inc_a == IO_LO_A);
  assign next_a    = skip ? RESUME_A : inc_a;
  assign sec_start = (next_a[SECTOR_W-1:0] == '0);
  assign rom_bank  = bank_q;
  assign done      = (ph_q == PH_DONE);

  always_comb begin
    op = '{kind: OP_IDLE, to_rom: 1'b1, addr: addr16, data: cap_q};
    case (ph_q)
      PH_RST: op.kind = OP_RESET;
      PH_ERASE: begin
        op.kind = OP_STORE;
        case (idx_q)
          3'd0, 3'd3: begin op.addr = KA; op.data = FL_KEY1; end
          3'd1, 3'd4: begin op.addr = KB; op.data = FL_KEY2; end
          3'd2:       begin op.addr = KA; op.data = FL_ERASE; end
          default:    op.data = FL_SECTOR;
        endcase
      end
      PH_UNLK: begin
        op.kind = OP_STORE;
        case (idx_q)
          3'd0:    begin op.addr = KA; op.data = FL_KEY1; end
          3'd1:    begin op.addr = KB; op.data = FL_KEY2; end
          default: begin op.addr = KA; op.data = FL_WRITE; end
        endcase
      end
      PH_LOAD: begin
        op.kind   = OP_LOAD;
        op.to_rom = !mode_q;
      end
      PH_STORE: begin
        op.kind   = OP_STORE;
        op.to_rom = mode_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_RST;
      idx_q  <= '0;
      addr_q <= '0;
      mode_q <= 1'b0;
      bank_q <= 1'b0;
    end else if (adv) begin
      case (ph_q)
        PH_RST: begin
          mode_q <= prog_mode;
          ph_q   <= prog_mode ? PH_ERASE : PH_LOAD;
        end
        PH_ERASE: begin
          idx_q <= (int'(idx_q) == ERASE_N - 1) ? '0 : idx_q + 1'b1;
          if (int'(idx_q) == ERASE_N - 1) ph_q <= PH_UNLK;
        end
        PH_UNLK: begin
          idx_q <= (int'(idx_q) == UNLK_N - 1) ? '0 : idx_q + 1'b1;
          if (int'(idx_q) == UNLK_N - 1) ph_q <= PH_LOAD;
        end
        PH_LOAD: ph_q <= PH_STORE;
        PH_STORE: begin
          addr_q <= next_a;
          if (skip) bank_q <= 1'b1;
          if (wrap)        ph_q <= PH_DONE;
          else if (!mode_q) ph_q <= PH_LOAD;
          else if (sec_start) ph_q <= PH_ERASE;
          else             ph_q <= PH_UNLK;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/inj_loader.sv
module inj_loader
  import ldr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IO_LO     = 'h6000,
  parameter int IO_RESUME = 'h8000,
  parameter int SECTOR_W  = 12,
  parameter int UNLK_A    = 'h5555,
  parameter int UNLK_B    = 'h2AAA,
  parameter int VEC       = 'h8000,
  parameter int PRE_RST   = 2,
  parameter int POST_RST  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_cyc,
  input  logic       cpu_rw,
  input  logic [7:0] bus_din,
  input  logic       prog_mode,
  output logic       cpu_rst_n,
  output logic [7:0] bus_dout,
  output logic       bus_oe,
  output logic       rom_cs,
  output logic       ram_cs,
  output logic       rom_bank,
  output logic       hold_off,
  output logic       done
);
  op_t        cur_op;
  logic       op_last, inj, adv;
  logic [7:0] inj_byte, cap_q;

  assign adv = bus_cyc && op_last;

  ldr_sched #(
    .ADDR_W(ADDR_W), .IO_LO(IO_LO), .IO_RESUME(IO_RESUME),
    .SECTOR_W(SECTOR_W), .UNLK_A(UNLK_A), .UNLK_B(UNLK_B)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .adv(adv), .prog_mode(prog_mode),
    .cap_q(cap_q), .op(cur_op), .rom_bank(rom_bank), .done(done)
  );

  ldr_prim #(
    .PRE_RST(PRE_RST), .POST_RST(POST_RST), .VEC(VEC)
  ) u_prim (
    .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .op(cur_op),
    .bus_din(bus_din), .inj(inj), .inj_byte(inj_byte), .rom_cs(rom_cs),
    .ram_cs(ram_cs), .cpu_rst_n(cpu_rst_n), .op_last(op_last), .cap_q(cap_q)
  );

  assign bus_oe   = inj && cpu_rw;
  assign bus_dout = bus_oe ? inj_byte : '0;
  assign hold_off = !done;
endmodule

// File: rtl/ldr_chk.sv
module ldr_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_cyc,
  input logic cpu_rw,
  input logic bus_oe,
  input logic rom_cs,
  input logic ram_cs,
  input logic cpu_rst_n,
  input logic rom_bank,
  input logic hold_off,
  input logic done
);
  AST_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> cpu_rw); // R10
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_cs})); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R7
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!hold_off && !bus_oe && !rom_cs && !ram_cs)); // R7
  AST_BANK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rom_bank |=> rom_bank); // R6
  AST_CPU_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_n |=> cpu_rst_n); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cyc |=> $stable({rom_cs, ram_cs, cpu_rst_n, rom_bank, done})); // R11
endmodule

bind inj_loader ldr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .cpu_rw(cpu_rw),
  .bus_oe(bus_oe), .rom_cs(rom_cs), .ram_cs(ram_cs), .cpu_rst_n(cpu_rst_n),
  .rom_bank(rom_bank), .hold_off(hold_off), .done(done)
);

// File: tb/tb_inj_loader.sv
module tb_inj_loader;
  localparam int AW      = 10;
  localparam int IO_LO   = 'h180;
  localparam int RESUME  = 'h200;
  localparam int SEC_W   = 7;
  localparam int KA      = 'h5555;
  localparam int KB      = 'h2AAA;
  localparam int VEC     = 'h8000;
  localparam int PRE     = 2;
  localparam int POST    = 5;
  localparam int WDOG    = 190000;

  logic clk = 1'b0, rst_n = 1'b0, bus_cyc = 1'b0, cpu_rw = 1'b1, prog_mode = 1'b0;
  logic [7:0] bus_din = '0;
  logic cpu_rst_n, bus_oe, rom_cs, ram_cs, rom_bank, hold_off, done;
  logic [7:0] bus_dout;

  always #2.5 clk = ~clk;

  inj_loader #(
    .ADDR_W(AW), .IO_LO(IO_LO), .IO_RESUME(RESUME), .SECTOR_W(SEC_W),
    .UNLK_A(KA), .UNLK_B(KB), .VEC(VEC), .PRE_RST(PRE), .POST_RST(POST)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .cpu_rw(cpu_rw),
    .bus_din(bus_din), .prog_mode(prog_mode), .cpu_rst_n(cpu_rst_n),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .rom_cs(rom_cs), .ram_cs(ram_cs),
    .rom_bank(rom_bank), .hold_off(hold_off), .done(done)
  );

  typedef struct {
    logic       inj;
    logic [7:0] b;
    logic       rcs, mcs, rst, rw, bank;
    logic [7:0] din;
    string      tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0, idx = 0;
  logic cur_bank;
  bit finished = 0;

  function automatic logic [7:0] rom_val(logic bank, int a);
    return 8'(a * 7 + int'(bank) * 91 + 3);
  endfunction
  function automatic logic [7:0] ram_val(int a);
    return 8'((a * 13) ^ 'h5A);
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (item %0d)", tag, got, exp, idx);
    end
  endtask

  task automatic push(logic inj, logic [7:0] b, logic rcs, logic mcs, logic rst,
                      logic rw, logic [7:0] din, string tag);
    item_t it;
    it.inj = inj; it.b = b; it.rcs = rcs; it.mcs = mcs; it.rst = rst;
    it.rw = rw; it.din = din; it.tag = tag; it.bank = cur_bank;
    q.push_back(it);
  endtask

  task automatic drv_reset();
    cur_bank = 1'b0;
    for (int i = 0; i < PRE; i++)  push(0, 0, 0, 0, 0, 1, 0, "R2");
    for (int i = 0; i < POST; i++) push(0, 0, 0, 0, 1, 1, 0, "R2");
    push(1, 8'(VEC), 0, 0, 1, 1, 0, "R2");
    push(1, 8'(VEC >> 8), 0, 0, 1, 1, 0, "R2");
  endtask

  task automatic drv_store(logic rom, int a, logic [7:0] d, string tag);
    push(1, 8'hA9, 0, 0, 1, 1, 0, tag);
    push(1, d, 0, 0, 1, 1, 0, tag);
    push(1, 8'h8D, 0, 0, 1, 1, 0, tag);
    push(1, 8'(a), 0, 0, 1, 1, 0, tag);
    push(1, 8'(a >> 8), 0, 0, 1, 1, 0, tag);
    push(0, 0, rom, !rom, 1, 0, 0, tag);
  endtask

  task automatic drv_load(logic rom, int a, logic [7:0] v, string tag);
    push(1, 8'h4C, 0, 0, 1, 1, 0, tag);
    push(1, 8'(VEC), 0, 0, 1, 1, 0, tag);
    push(1, 8'(VEC >> 8), 0, 0, 1, 1, 0, tag);
    push(1, 8'hAD, 0, 0, 1, 1, 0, tag);
    push(1, 8'(a), 0, 0, 1, 1, 0, tag);
    push(1, 8'(a >> 8), 0, 0, 1, 1, 0, tag);
    push(0, 0, rom, !rom, 1, 1, v, tag);
  endtask

  task automatic drv_run(bit prog);
    int a = 0;
    drv_reset();
    while (a < (1 << AW)) begin
      if (!prog) begin
        drv_load(1, a, rom_val(cur_bank, a), "R4");
        drv_store(0, a, rom_val(cur_bank, a), "R5");
      end else begin
        if (a % (1 << SEC_W) == 0) begin
          drv_store(1, KA, 8'hAA, "R9"); drv_store(1, KB, 8'h55, "R9");
          drv_store(1, KA, 8'h80, "R9"); drv_store(1, KA, 8'hAA, "R9");
          drv_store(1, KB, 8'h55, "R9"); drv_store(1, a, 8'h30, "R9");
        end
        drv_store(1, KA, 8'hAA, "R8"); drv_store(1, KB, 8'h55, "R8");
        drv_store(1, KA, 8'hA0, "R8");
        drv_load(0, a, ram_val(a), "R8");
        drv_store(1, a, ram_val(a), "R8");
      end
      a++;
      if (a == IO_LO) begin a = RESUME; cur_bank = 1'b1; end
    end
  endtask

  task automatic cmp(item_t it, logic rwd, string tag);
    logic eoe;
    bit ok;
    eoe = it.inj && rwd;
    ok = (bus_oe == eoe) && (!eoe || bus_dout == it.b) && rom_cs == it.rcs &&
         ram_cs == it.mcs && cpu_rst_n == it.rst && !done && hold_off;
    check(ok, tag, {8'h0, bus_oe, bus_dout, rom_cs, ram_cs, cpu_rst_n, done, hold_off, 11'h0},
          {8'h0, eoe, it.b, it.rcs, it.mcs, it.rst, 1'b0, 1'b1, 11'h0});
    check(rom_bank == it.bank, "R6", 32'(rom_bank), 32'(it.bank));
  endtask

  task automatic monitor();
    while (q.size() > 0) begin
      item_t it;
      logic rwd;
      bit force0;
      it = q.pop_front();
      idx++;
      force0 = it.inj && (idx % 29 == 5);
      rwd = force0 ? 1'b0 : it.rw;
      @(negedge clk); bus_cyc = 1'b0; cpu_rw = rwd; bus_din = it.din;
      #1 cmp(it, rwd, "R11");
      @(negedge clk); bus_cyc = 1'b1;
      #1 cmp(it, rwd, force0 ? "R10" : it.tag);
      @(posedge clk);
    end
  endtask

  task automatic check_done();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); bus_cyc = 1'b1; cpu_rw = 1'b1;
      #1 check(done && !hold_off && !bus_oe && !rom_cs && !ram_cs, "R7",
               {27'h0, done, hold_off, bus_oe, rom_cs, ram_cs}, 32'h10);
    end
  endtask

  task automatic check_reset();
    @(negedge clk); bus_cyc = 1'b1; cpu_rw = 1'b1;
    #1 check(!cpu_rst_n && !bus_oe && !rom_cs && !ram_cs && !done && hold_off, "R1",
             {26'h0, cpu_rst_n, bus_oe, rom_cs, ram_cs, done, hold_off}, 32'h1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < WDOG; c++) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    drv_run(0);
    @(negedge clk); bus_cyc = 1'b0; rst_n = 1'b1;
    monitor();
    check_done();

    @(negedge clk); rst_n = 1'b0; prog_mode = 1'b1; bus_cyc = 1'b0;
    repeat (2) @(negedge clk);
    check_reset();
    idx = 0;
    drv_run(1);
    @(negedge clk); bus_cyc = 1'b0; rst_n = 1'b1;
    monitor();
    check_done();
    finished = 1;
    summary();
  end
endmodule